// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block derives two families of divided clocks from a single input clock. Bank A runs at one half or one quarter of the input frequency. Bank B runs at one quarter, one fifth or one sixth of it. Each bank drives a set of output pairs, and each pair carries a true signal and its inverse. Every ratio, including the odd one, has a 50% duty cycle. The divide-by-five case uses a falling-edge flop to cut the high phase half an input cycle short of the third rising edge.

An active-low clock enable is resynchronised inside the block. It passes through a rising-edge flop and then a falling-edge flop. Each bank acts on the result only at its own period boundary, so a stop or a restart can never cut a pulse short. The select inputs are also sampled only at a bank's period boundary. An asynchronous active-low master reset clears all divider state and forces every true output low. When it is released, both banks leave their idle state on the same input edge, so their edges stay aligned.

Top module: `dual_bank_clk_div`

## Requirements
- R1: While rst_ni is low, every bit of qa_o and qb_o is 0 and every bit of qa_n_o and qb_n_o is 1. The reset acts asynchronously.
- R2: rst_ni is released before rising edge k, and clk_en_ni is 0. Then qa_o and qb_o both go high on rising edge k+1 and not earlier.
- R3: Bank A divides by 2 when sel_a_i is 0 and by 4 when sel_a_i is 1. Its output is high for the first half of each period, counted from the rising edge that opens the period.
- R4: Bank B takes its ratio from {sel_b_i[1], sel_b_i[0]}: 00 gives 4, 01 gives 6, 10 gives 5 and 11 gives 5.
- R5: At the ratio of 5, qb_o is high for two and a half input cycles. It rises on a rising edge and falls on the falling edge inside the third input cycle of the period.
- R6: clk_en_ni is sampled high on a rising edge. After the following falling edge, each bank completes its current period. It then stops with the true outputs held low and the complements held high.
- R7: While a bank is stopped, clk_en_ni is sampled low on rising edge k. Both banks then restart with a rising output edge on rising edge k+1. A stopped bank resumes from the start of its period.
- R8: A change of sel_a_i or sel_b_i takes effect only on the rising edge that opens the next period of the bank concerned. A period already in progress keeps its length.
- R9: All pairs of a bank carry identical true outputs, and each complement is the exact inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| clk_en_ni | input | 1 | Output enable, active low, asynchronous to clk_i |
| sel_a_i | input | 1 | Bank A ratio select |
| sel_b_i | input | 2 | Bank B ratio select code |
| qa_o | output | PAIRS_A (2) | Bank A true outputs |
| qa_n_o | output | PAIRS_A (2) | Bank A complementary outputs |
| qb_o | output | PAIRS_B (2) | Bank B true outputs |
| qb_n_o | output | PAIRS_B (2) | Bank B complementary outputs |

## Verification
All outputs are registered. A select or enable value sampled on a rising edge therefore shows first at that bank's next period boundary. An enable change adds one more rising edge, because it must also pass the falling-edge stage. The divide-by-five fall shows half a cycle after a rising edge. For this reason the bench compares all outputs twice per input cycle: 5 ns after each rising edge and 5 ns after each falling edge. An edge-accurate model queues the expected value for both phases on every rising edge. It changes inputs only 7 ns after a falling edge, so every sample sees settled values from one known edge.

// File: rtl/dbcd_pkg.sv
package dbcd_pkg;
  parameter int unsigned RATIO_W = 3;
  typedef logic [RATIO_W-1:0] ratio_t;

  function automatic ratio_t bank_a_ratio(input logic sel);
    return sel ? ratio_t'(4) : ratio_t'(2);
  endfunction

  // {sel1, sel0}: 00->4, 01->6, 1x->5
  function automatic ratio_t bank_b_ratio(input logic [1:0] sel);
    case (sel)
      2'b00:   return ratio_t'(4);
      2'b01:   return ratio_t'(6);
      default: return ratio_t'(5);
    endcase
  endfunction
endpackage

// File: rtl/dbcd_en_sync.sv
module dbcd_en_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_en_ni,
  output logic run_o
);
  logic en_p_q;
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_p_q <= 1'b0;
    else         en_p_q <= ~clk_en_ni;

  // second stage on the falling edge: rise then fall before any effect
  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_p_q;

  assign run_o = run_q;

  assert_run_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q == en_p_q);
endmodule

// File: rtl/dbcd_bank.sv
module dbcd_bank #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             q_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ratio_q, ratio_d;
  logic             pos_q, pos_d;
  logic             neg_q, neg_d;
  logic             wrap;
  logic [EXT_W-1:0] hi_len;

  assign wrap = !active_q || (cnt_q == ratio_q - CNT_W'(1));

  always_comb begin
    active_d = active_q;
    ratio_d  = ratio_q;
    cnt_d    = cnt_q + CNT_W'(1);
    if (wrap) begin
      active_d = run_i;
      ratio_d  = ratio_i;
      cnt_d    = '0;
    end
    hi_len = (EXT_W'(ratio_d) + EXT_W'(1)) >> 1;
    pos_d  = active_d && (EXT_W'(cnt_d) < hi_len);
  end

  // odd ratio: trim the last high cycle at its falling edge
  assign neg_d = !(active_q && ratio_q[0] && (cnt_q == (ratio_q >> 1)));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      ratio_q  <= CNT_W'(2);
      pos_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      ratio_q  <= ratio_d;
      pos_q    <= pos_d;
    end

  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) neg_q <= 1'b1;
    else         neg_q <= neg_d;

  assign q_o = pos_q & neg_q;

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < ratio_q));
  assert_ratio_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(ratio_q));
  assert_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !q_o);
  assert_trim_odd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !neg_q |-> ratio_q[0]);
endmodule

// File: rtl/dual_bank_clk_div.sv
module dual_bank_clk_div
  import dbcd_pkg::*;
#(
  parameter int unsigned PAIRS_A = 2,
  parameter int unsigned PAIRS_B = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clk_en_ni,
  input  logic               sel_a_i,
  input  logic [1:0]         sel_b_i,
  output logic [PAIRS_A-1:0] qa_o,
  output logic [PAIRS_A-1:0] qa_n_o,
  output logic [PAIRS_B-1:0] qb_o,
  output logic [PAIRS_B-1:0] qb_n_o
);
  logic   run;
  logic   qa, qb;
  ratio_t ratio_a, ratio_b;

  assign ratio_a = bank_a_ratio(sel_a_i);
  assign ratio_b = bank_b_ratio(sel_b_i);

  dbcd_en_sync u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_en_ni(clk_en_ni),
    .run_o    (run)
  );

  dbcd_bank #(.CNT_W(RATIO_W)) u_bank_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .ratio_i(ratio_a),
    .q_o    (qa)
  );

  dbcd_bank #(.CNT_W(RATIO_W)) u_bank_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .ratio_i(ratio_b),
    .q_o    (qb)
  );

  for (genvar i = 0; i < PAIRS_A; i++) begin : g_pair_a
    assign qa_o[i]   = qa;
    assign qa_n_o[i] = ~qa;
  end

  for (genvar i = 0; i < PAIRS_B; i++) begin : g_pair_b
    assign qb_o[i]   = qb;
    assign qb_n_o[i] = ~qb;
  end
endmodule

// File: tb/sim_dual_bank_clk_div.sv
module sim_dual_bank_clk_div;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clk_en_ni = 1'b0;
  logic       sel_a_i = 1'b0;
  logic [1:0] sel_b_i = 2'b00;
  logic [1:0] qa_o, qa_n_o, qb_o, qb_n_o;

  always #10 clk = ~clk;

  dual_bank_clk_div u0 (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i),
    .qa_o(qa_o), .qa_n_o(qa_n_o), .qb_o(qb_o), .qb_n_o(qb_n_o)
  );

  logic [7:0] exp_q[$];
  string      tag_q[$];
  string      cur_tag = "R1";
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  // reference model, one entry per bank (0 = A, 1 = B)
  bit m_enp = 1'b0;
  bit m_act[2];
  int m_cnt[2];
  int m_rat[2];

  function automatic int ratio_of(input int bank);
    if (bank == 0) return sel_a_i ? 4 : 2;
    case (sel_b_i)
      2'b00:   return 4;
      2'b01:   return 6;
      default: return 5;
    endcase
  endfunction

  function automatic logic [7:0] expect_vec(input bit hi_phase);
    logic q[2];
    for (int b = 0; b < 2; b++)
      q[b] = m_act[b] && (m_cnt[b] < (hi_phase ? (m_rat[b] + 1) / 2 : m_rat[b] / 2));
    return {{2{q[0]}}, {2{~q[0]}}, {2{q[1]}}, {2{~q[1]}}};
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_enp = 1'b0;
      for (int b = 0; b < 2; b++) begin
        m_act[b] = 1'b0; m_cnt[b] = 0; m_rat[b] = 2;
      end
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (!m_act[b] || m_cnt[b] == m_rat[b] - 1) begin
          m_rat[b] = ratio_of(b);
          m_act[b] = m_enp;
          m_cnt[b] = 0;
        end else begin
          m_cnt[b] = m_cnt[b] + 1;
        end
      end
      m_enp = ~clk_en_ni;
    end
    exp_q.push_back(expect_vec(1'b1)); tag_q.push_back(cur_tag);
    exp_q.push_back(expect_vec(1'b0)); tag_q.push_back(cur_tag);
  end

  task automatic compare();
    logic [7:0] got, want;
    string      t;
    if (exp_q.size() == 0) return;
    want = exp_q.pop_front();
    t    = tag_q.pop_front();
    got  = {qa_o, qa_n_o, qb_o, qb_n_o};
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s t=%0t actual={qa,qa_n,qb,qb_n}=%b expected=%b", t, $time, got, want);
    end
  endtask

  always @(posedge clk) begin
    #5  compare();
    #10 compare();
  end

  task automatic apply(input bit r, input bit en_n, input bit sa, input logic [1:0] sb,
                       input string tag, input int n);
    @(negedge clk); #7;
    rst_ni = r; clk_en_ni = en_n; sel_a_i = sa; sel_b_i = sb; cur_tag = tag;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    apply(0, 0, 0, 2'b00, "R1", 4);
    apply(1, 0, 0, 2'b00, "R2", 12);
    apply(1, 0, 1, 2'b00, "R3", 16);
    apply(1, 0, 0, 2'b10, "R4", 20);
    apply(1, 0, 0, 2'b01, "R4", 24);
    apply(1, 0, 1, 2'b11, "R5", 20);
    for (int i = 0; i < 12; i++)
      apply(1, 0, i[0], 2'(i + (i >> 2)), "R8", 3);
    apply(1, 1, 1, 2'b10, "R6", 20);
    apply(1, 0, 1, 2'b10, "R7", 20);
    apply(1, 1, 0, 2'b01, "R6", 1);
    apply(1, 0, 0, 2'b01, "R7", 16);
    apply(1, 0, 0, 2'b11, "R9", 12);
    apply(0, 0, 0, 2'b11, "R1", 3);
    apply(1, 0, 1, 2'b10, "R2", 12);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule